// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a parallel input port and raises an active-low, open-drain interrupt request when any port bit differs from a stored reference snapshot. A remote host can then learn that input data changed without polling the serial bus. The request is withdrawn in two ways. If the inputs move back to the snapshot value before any access, the request drops by itself. An access to this port also clears it, and that clear comes at a specific serial-clock edge of the acknowledge bit, which depends on the transfer direction.

The bus controller gives two level inputs. One marks the acknowledge bit of a read addressed to this port, and the other marks the acknowledge bit of a write addressed to this port. Two single-cycle strobes mark the rising and falling serial-clock edges. A clear happens on a rising edge while the read acknowledge is high, or on a falling edge while the write acknowledge is high. At each clear the snapshot is loaded with the current port value. After a clear the comparison is blind until the next rising serial-clock edge. At that edge, any difference that has built up is reported.

The controller is a three-state machine:
- QUIET: request released.
- ALERT: request driven.
- BLIND: released after a clear, waiting for a rising edge.

The transitions are:
- QUIET to ALERT when the port differs from the snapshot.
- ALERT to QUIET when the port equals the snapshot again.
- BLIND to ALERT or to QUIET at a rising edge, depending on the comparison at that edge.
- Any state to BLIND on a clear, which overrides every other transition.

Top module: `port_change_irq`

## Requirements
- R1: After reset the interrupt enable `int_pull_o` is 0 (line released), the snapshot holds all ones, and the machine is in QUIET.
- R2: In QUIET, when `port_i` differs from the snapshot in any bit, in either direction, `int_pull_o` is 1 from the clock edge that samples the difference.
- R3: In ALERT, when `port_i` equals the snapshot again and no clear occurs, `int_pull_o` returns to 0 at the next clock edge.
- R4: A read clear (`rd_ack_i`=1 and `scl_rise_i`=1 in the same cycle) sets `int_pull_o` to 0 at the next edge and enters BLIND.
- R5: A write clear (`wr_ack_i`=1 and `scl_fall_i`=1 in the same cycle) sets `int_pull_o` to 0 at the next edge and enters BLIND.
- R6: Serial-clock edges without the matching acknowledge have no effect on the snapshot or on `int_pull_o`. This covers a falling edge during a read acknowledge, a rising edge during a write acknowledge, and traffic for other slaves (edges with both acknowledges low).
- R7: In BLIND, `int_pull_o` stays 0 until a rising edge (`scl_rise_i`=1). At that edge the machine goes to ALERT if the port differs from the snapshot, and to QUIET otherwise.
- R8: At every clear the snapshot is loaded with the `port_i` value of the clear cycle. A port change that arrives in that same cycle is therefore absorbed and never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| port_i | input | PORT_W | Synchronized port pin values |
| rd_ack_i | input | 1 | High during the acknowledge bit of a read of this port |
| wr_ack_i | input | 1 | High during the acknowledge bit of a write to this port |
| scl_rise_i | input | 1 | One-cycle strobe on a rising serial-clock edge |
| scl_fall_i | input | 1 | One-cycle strobe on a falling serial-clock edge |
| int_pull_o | output | 1 | Open-drain enable: 1 pulls the interrupt line low, 0 releases it |

## Verification
Two functions can fall in the same cycle: the clear, which loads the snapshot, and change detection, which compares against it. The bench drives a new port value in the very cycle of a read clear and in the very cycle of a write clear. It expects the change to be absorbed, with no request at the later rising edge. It also changes the port during BLIND and judges that the request appears exactly at the following rising-edge strobe and not before. A behavioural model in the bench, built from two flags and a snapshot word, predicts `int_pull_o` for every clock.

// File: rtl/pcig_pkg.sv
package pcig_pkg;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_ALERT = 2'd1,
        ST_BLIND = 2'd2
    } pcig_state_e;

endpackage

// File: rtl/pcig_clear_decode.sv
module pcig_clear_decode (
    input  logic rd_ack_i,
    input  logic wr_ack_i,
    input  logic scl_rise_i,
    input  logic scl_fall_i,
    output logic clear_o
);

    logic rd_clear;
    logic wr_clear;

    // read acknowledge resolves on the rising edge, write on the falling edge
    always_comb begin
        rd_clear = rd_ack_i & scl_rise_i;
        wr_clear = wr_ack_i & scl_fall_i;
        clear_o  = rd_clear | wr_clear;
    end

endmodule

// File: rtl/pcig_snapshot.sv
module pcig_snapshot #(
    parameter int unsigned         PORT_W    = 8,
    parameter logic [PORT_W-1:0]   INIT_VAL  = '1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [PORT_W-1:0] value_i,
    output logic [PORT_W-1:0] snap_o
);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            snap_o <= INIT_VAL;
        end else if (load_i) begin
            snap_o <= value_i;
        end
    end

endmodule

// File: rtl/pcig_compare.sv
module pcig_compare #(
    parameter int unsigned PORT_W = 8
) (
    input  logic [PORT_W-1:0] port_i,
    input  logic [PORT_W-1:0] snap_i,
    output logic              differs_o
);

    logic [PORT_W-1:0] bit_diff;

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        assign bit_diff[b] = port_i[b] ^ snap_i[b];
    end

    assign differs_o = |bit_diff;

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
    import pcig_pkg::*;
#(
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PORT_W-1:0] port_i,
    input  logic              rd_ack_i,
    input  logic              wr_ack_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    output logic              int_pull_o
);

    localparam logic [PORT_W-1:0] SNAP_INIT = {PORT_W{1'b1}};

    pcig_state_e       state_q;
    pcig_state_e       state_d;
    logic              clear;
    logic              differs;
    logic [PORT_W-1:0] snap_q;

    pcig_clear_decode i_decode (
        .rd_ack_i   (rd_ack_i),
        .wr_ack_i   (wr_ack_i),
        .scl_rise_i (scl_rise_i),
        .scl_fall_i (scl_fall_i),
        .clear_o    (clear)
    );

    pcig_snapshot #(
        .PORT_W   (PORT_W),
        .INIT_VAL (SNAP_INIT)
    ) i_snapshot (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (clear),
        .value_i (port_i),
        .snap_o  (snap_q)
    );

    pcig_compare #(
        .PORT_W (PORT_W)
    ) i_compare (
        .port_i    (port_i),
        .snap_i    (snap_q),
        .differs_o (differs)
    );

    // next-state logic; a clear overrides every other transition
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_BLIND;
        end else begin
            unique case (state_q)
                ST_QUIET: if (differs)    state_d = ST_ALERT;
                ST_ALERT: if (!differs)   state_d = ST_QUIET;
                ST_BLIND: if (scl_rise_i) state_d = differs ? ST_ALERT : ST_QUIET;
                default:                  state_d = ST_QUIET;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        int_pull_o = (state_q == ST_ALERT);
    end

    // R1: the line is released right after reset
    assert_reset_release_R1: assert property (@(posedge clk_i)
        !rst_ni |=> !int_pull_o);

    // R2: a mismatch seen in QUIET raises the request
    assert_detect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_QUIET && differs && !clear) |=> int_pull_o);

    // R3: return to the reference withdraws the request
    assert_self_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ALERT && !differs && !clear) |=> !int_pull_o);

    // R4: read acknowledge resolves on the rising edge
    assert_read_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_ack_i && scl_rise_i) |=> !int_pull_o);

    // R5: write acknowledge resolves on the falling edge
    assert_write_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ack_i && scl_fall_i) |=> !int_pull_o);

    // R6: without a clear the reference is untouched
    assert_snap_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear |=> $stable(snap_q));

    // R7: blind window keeps the line released until a rising edge
    assert_blind_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BLIND && !scl_rise_i && !clear) |=> !int_pull_o);

    // R8: the snapshot takes the port value of the clear cycle
    assert_snap_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear |=> (snap_q == $past(port_i)));

endmodule

// File: tb/test_port_change_irq.sv
`timescale 1ns/100ps
module test_port_change_irq;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] port;
    logic         rd_ack;
    logic         wr_ack;
    logic         scl_rise;
    logic         scl_fall;
    logic         int_pull;

    int n_checks = 0;
    int n_fail   = 0;
    string phase = "R1";

    // behavioural reference
    logic [W-1:0] m_snap;
    bit           m_pend;
    bit           m_blind;

    always #2.5 clk = ~clk;

    port_change_irq #(.PORT_W(W)) i_port_change_irq (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .port_i     (port),
        .rd_ack_i   (rd_ack),
        .wr_ack_i   (wr_ack),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .int_pull_o (int_pull)
    );

    task automatic check(input bit exp, input string req);
        n_checks++;
        if (int_pull !== exp) begin
            n_fail++;
            $display("FAIL %s: int_pull=%b expected %b at %0t", req, int_pull, exp, $time);
        end
    endtask

    // one clock: update model at the edge, compare away from it
    task automatic tick();
        bit clr;
        @(posedge clk);
        clr = (rd_ack && scl_rise) || (wr_ack && scl_fall);
        if (!rst_n) begin
            m_snap = '1; m_pend = 0; m_blind = 0;
        end else if (clr) begin
            m_snap = port; m_pend = 0; m_blind = 1;
        end else if (m_blind) begin
            if (scl_rise) begin
                m_blind = 0;
                m_pend  = (port != m_snap);
            end
        end else begin
            m_pend = (port != m_snap);
        end
        @(negedge clk);
        check(m_pend, phase);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic rise_pulse();
        scl_rise = 1; tick(); scl_rise = 0;
    endtask

    task automatic fall_pulse();
        scl_fall = 1; tick(); scl_fall = 0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; port = '1; rd_ack = 0; wr_ack = 0; scl_rise = 0; scl_fall = 0;
        m_snap = '1; m_pend = 0; m_blind = 0;
        @(negedge clk);
        ticks(3);
        rst_n = 1;
        phase = "R1";
        tick();
        check(1'b0, "R1");
        // snapshot all ones: clearing bit 0 must be seen
        phase = "R2"; port = 8'hFE; tick();
        check(1'b1, "R2");
        phase = "R3"; port = 8'hFF; tick();
        check(1'b0, "R3");

        // every bit, both directions, relative to all ones
        for (int b = 0; b < W; b++) begin
            phase = "R2"; port = 8'hFF; port[b] = 1'b0; ticks(2);
            check(1'b1, "R2");
            phase = "R3"; port = 8'hFF; tick();
            check(1'b0, "R3");
        end

        // read clear with port at zero
        phase = "R4"; port = 8'h00; ticks(2);
        rd_ack = 1; rise_pulse();
        check(1'b0, "R4");
        rd_ack = 0; ticks(2);
        phase = "R7"; rise_pulse();
        check(1'b0, "R7");
        // rising change relative to snapshot 00
        phase = "R2"; port = 8'h01; ticks(2);
        check(1'b1, "R2");

        // wrong edges and other-slave traffic
        phase = "R6";
        rd_ack = 1; fall_pulse(); rd_ack = 0;
        check(1'b1, "R6");
        wr_ack = 1; rise_pulse(); wr_ack = 0;
        check(1'b1, "R6");
        for (int k = 0; k < 4; k++) begin rise_pulse(); fall_pulse(); end
        check(1'b1, "R6");
        // snapshot must still be 00: port back to 00 drops request
        phase = "R3"; port = 8'h00; tick();
        check(1'b0, "R6");
        phase = "R2"; port = 8'h01; tick();

        // write clear on the falling edge
        phase = "R5"; wr_ack = 1; rise_pulse(); fall_pulse(); wr_ack = 0;
        check(1'b0, "R5");
        // blind window: change is held back until a rising edge
        phase = "R7"; port = 8'h81; ticks(3);
        check(1'b0, "R7");
        fall_pulse();
        check(1'b0, "R7");
        rise_pulse();
        check(1'b1, "R7");
        // change that reverts before the rising edge is never reported
        phase = "R5"; wr_ack = 1; fall_pulse(); wr_ack = 0;
        phase = "R7"; port = 8'hC1; ticks(2); port = 8'h81; tick();
        rise_pulse();
        check(1'b0, "R7");

        // change in the clear cycle itself is absorbed
        phase = "R8"; port = 8'hFF; rd_ack = 1; rise_pulse(); rd_ack = 0;
        ticks(2); rise_pulse();
        check(1'b0, "R8");
        port = 8'h3C; wr_ack = 1; fall_pulse(); wr_ack = 0;
        ticks(2); rise_pulse();
        check(1'b0, "R8");
        phase = "R2"; port = 8'h3D; tick();
        check(1'b1, "R2");

        // reset in mid-alert releases and restores all-ones reference
        phase = "R1"; rst_n = 0; ticks(2); rst_n = 1; port = 8'hFF; tick();
        check(1'b0, "R1");
        ticks(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule